// File: doc/BRIEF.md
# Parallel EPROM Read Access Controller

This block lets a synchronous system read bytes from an asynchronous parallel EPROM. A host raises a request with a 16-bit byte address. While idle, the controller takes the request at the next clock edge. It drives the address, pulls chip enable low and, after a computed offset, pulls output enable low. It then waits a whole number of clock cycles that covers the part's access time and samples the data bus. The byte comes back with a one-cycle valid pulse. All delays are worked out at elaboration from the clock period parameter and the nanosecond figures of three speed grades. A two-bit input picks the grade for each request.

Output enable is normally held back relative to chip enable, by no more than the slack between the access time and the output-enable delay, so the access does not get longer. After the controller releases the device, busy stays high for the output float time, so the next device on a shared bus is not enabled too early. An identifier request places the high-voltage line of the address bus in its marked state and raises a high-voltage-request output. Address bit 0 then chooses between the maker code and the device code.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is low, mem_ce_n and mem_oe_n are 1 and busy, rsp_valid and mem_hv_req are 0.
- R2: A request with req_valid high while busy is low is accepted at the next rising edge. At that edge mem_ce_n goes low, mem_addr takes the request address and busy goes high.
- R3: The data bus is sampled at the edge ceil(tACC/T)+1 cycles after the accept edge, where T is the clock period. The sampled byte appears on rsp_data with rsp_valid high for that cycle. mem_ce_n, mem_oe_n and mem_hv_req are released at the same edge.
- R4: Grade code 0 uses tACC/tOE/tDF = 90/40/35 ns, code 1 uses 120/50/25 ns, and codes 2 and 3 use 150/50/45 ns. The grade is captured at accept, so a later change of the grade input does not affect the access in progress.
- R5: With late output enable (default), mem_oe_n falls floor((tACC-tOE)/T) cycles after mem_ce_n falls. With that option off, both fall together.
- R6: busy stays high for ceil(tDF/T) cycles after mem_ce_n is released. A request seen while busy is high has no effect: no new access starts, and no address, grade or kind of access is taken from it.
- R7: An identifier request (req_id high) drives mem_addr with bit 9 set, bit 0 equal to req_addr bit 0 and every other bit 0. mem_hv_req is high exactly while mem_ce_n is low for that access.
- R8: mem_oe_n is low only while mem_ce_n is low, and mem_addr does not change while mem_ce_n stays low.
- R9: rsp_valid is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request |
| req_id | input | 1 | Request is an identifier read |
| req_addr | input | 16 | Byte address; for an identifier read, bit 0 selects the code |
| grade | input | 2 | Speed-grade select |
| busy | output | 1 | Access or float interval in progress |
| rsp_valid | output | 1 | One-cycle pulse with returned byte |
| rsp_data | output | 8 | Returned byte |
| mem_addr | output | 16 | Address bus to the EPROM |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_hv_req | output | 1 | Request for high voltage on address line 9 |
| mem_data | input | 8 | Data bus from the EPROM |

## Verification
Single reads are run in each of the four grade codes. The bench's EPROM model returns a junk byte until both the access time and the output-enable delay have really elapsed, so a sample taken one cycle early shows up as a data error rather than passing by luck. Identifier reads with bit 0 at both values check the address pattern, the high-voltage request and the code selection. Requests pulsed in the middle of an access, a grade change during an access, and a request held high across several accesses separate "ignored while busy" and "grade latched at accept" from a design that reacts to its live inputs. They also show that a new chip enable waits out the full float interval.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

   typedef enum logic [1:0] {
      RD_IDLE   = 2'd0,
      RD_ACCESS = 2'd1,
      RD_FLOAT  = 2'd2
   } rd_phase_e;

   localparam int NUM_GRADES = 4;

   // address / chip-enable to data, ns
   function automatic int grade_acc_ns(input int g);
      case (g)
         0:       return 90;
         1:       return 120;
         default: return 150;
      endcase
   endfunction

   // output-enable to data, ns
   function automatic int grade_oe_ns(input int g);
      case (g)
         0:       return 40;
         default: return 50;
      endcase
   endfunction

   // disable to bus float, ns
   function automatic int grade_df_ns(input int g);
      case (g)
         0:       return 35;
         1:       return 25;
         default: return 45;
      endcase
   endfunction

   function automatic int ceil_div(input int n, input int d);
      return (n + d - 1) / d;
   endfunction

endpackage

// File: rtl/eprom_rd_timing.sv
module eprom_rd_timing
   import eprom_rd_pkg::*;
#(
   parameter int CLK_PERIOD_NS = 10,
   parameter int CNT_W         = 8,
   parameter bit OE_LATE       = 1'b1
) (
   input  logic [1:0]       grade,
   output logic [CNT_W-1:0] acc_cycles,
   output logic [CNT_W-1:0] oe_cycles,
   output logic [CNT_W-1:0] df_cycles
);

   logic [CNT_W-1:0] acc_tab [NUM_GRADES];
   logic [CNT_W-1:0] oe_tab  [NUM_GRADES];
   logic [CNT_W-1:0] df_tab  [NUM_GRADES];

   if (CLK_PERIOD_NS < 1) begin : g_bad_period
      $error("eprom_rd_timing: CLK_PERIOD_NS must be positive");
   end

   for (genvar g = 0; g < NUM_GRADES; g++) begin : g_grade
      // one cycle of margin beyond the rounded-up access time
      localparam int ACC_C = ceil_div(grade_acc_ns(g), CLK_PERIOD_NS) + 1;
      localparam int DF_C  = ceil_div(grade_df_ns(g), CLK_PERIOD_NS);

      if (ACC_C >= 2 ** CNT_W || DF_C >= 2 ** CNT_W) begin : g_bad_width
         $error("eprom_rd_timing: CNT_W too narrow for the clock period");
      end

      assign acc_tab[g] = CNT_W'(ACC_C);
      assign df_tab[g]  = CNT_W'(DF_C);

      if (OE_LATE) begin : g_late_oe
         // rounded down so the output-enable path never sets the access time
         localparam int OE_C = (grade_acc_ns(g) - grade_oe_ns(g)) / CLK_PERIOD_NS;
         assign oe_tab[g] = CNT_W'(OE_C);
      end else begin : g_early_oe
         assign oe_tab[g] = '0;
      end
   end

   assign acc_cycles = acc_tab[grade];
   assign oe_cycles  = oe_tab[grade];
   assign df_cycles  = df_tab[grade];

endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
   import eprom_rd_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 8,
   parameter int ID_LINE = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_id,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CNT_W-1:0]  acc_cycles,
   input  logic [CNT_W-1:0]  oe_cycles,
   input  logic [CNT_W-1:0]  df_cycles,
   input  logic [DATA_W-1:0] mem_data,
   output logic              busy,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_hv_req
);

   rd_phase_e        phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] acc_q;
   logic [CNT_W-1:0] oe_q;
   logic [CNT_W-1:0] df_q;
   logic [ADDR_W-1:0] id_addr;

   assign cnt_nxt = cnt_q + 1'b1;
   assign busy    = (phase_q != RD_IDLE);

   always_comb begin
      id_addr          = '0;
      id_addr[ID_LINE] = 1'b1;
      id_addr[0]       = req_addr[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q    <= RD_IDLE;
         cnt_q      <= '0;
         acc_q      <= '0;
         oe_q       <= '0;
         df_q       <= '0;
         mem_addr   <= '0;
         mem_ce_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_hv_req <= 1'b0;
         rsp_valid  <= 1'b0;
         rsp_data   <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (phase_q)
            RD_IDLE: begin
               if (req_valid) begin
                  phase_q    <= RD_ACCESS;
                  cnt_q      <= '0;
                  acc_q      <= acc_cycles;
                  oe_q       <= oe_cycles;
                  df_q       <= df_cycles;
                  mem_addr   <= req_id ? id_addr : req_addr;
                  mem_hv_req <= req_id;
                  mem_ce_n   <= 1'b0;
                  mem_oe_n   <= (oe_cycles != '0);
               end
            end
            RD_ACCESS: begin
               cnt_q <= cnt_nxt;
               if (cnt_nxt == oe_q) begin
                  mem_oe_n <= 1'b0;
               end
               if (cnt_nxt == acc_q) begin
                  rsp_valid  <= 1'b1;
                  rsp_data   <= mem_data;
                  mem_ce_n   <= 1'b1;
                  mem_oe_n   <= 1'b1;
                  mem_hv_req <= 1'b0;
                  cnt_q      <= '0;
                  phase_q    <= RD_FLOAT;
               end
            end
            RD_FLOAT: begin
               cnt_q <= cnt_nxt;
               if (cnt_nxt == df_q) begin
                  phase_q <= RD_IDLE;
               end
            end
            default: phase_q <= RD_IDLE;
         endcase
      end
   end

   // ---- checker state: cycles chip enable has been high, float need of last access
   logic [CNT_W-1:0] gap_q;
   logic [CNT_W-1:0] df_last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q     <= '1;
         df_last_q <= '0;
      end else begin
         if (!mem_ce_n) begin
            gap_q <= '0;
         end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
         end
         if (phase_q == RD_ACCESS && cnt_nxt == acc_q) begin
            df_last_q <= df_q;
         end
      end
   end

   // R8
   oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_ce_n);

   // R8
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   // R9
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R7
   hv_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_hv_req |-> !mem_ce_n);

   // R2
   ce_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> busy);

   // R6
   float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> (gap_q >= df_last_q));

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
   import eprom_rd_pkg::*;
#(
   parameter int CLK_PERIOD_NS = 10,
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int CNT_W         = 8,
   parameter int ID_LINE       = 9,
   parameter bit OE_LATE       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_id,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        grade,
   output logic              busy,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_hv_req,
   input  logic [DATA_W-1:0] mem_data
);

   if (ID_LINE < 1 || ID_LINE >= ADDR_W) begin : g_bad_id_line
      $error("eprom_rd_ctrl: ID_LINE must lie above bit 0 and inside the address");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("eprom_rd_ctrl: DATA_W must be positive");
   end

   logic [CNT_W-1:0] acc_cycles;
   logic [CNT_W-1:0] oe_cycles;
   logic [CNT_W-1:0] df_cycles;

   eprom_rd_timing #(
      .CLK_PERIOD_NS(CLK_PERIOD_NS),
      .CNT_W        (CNT_W),
      .OE_LATE      (OE_LATE)
   ) i_timing (
      .grade     (grade),
      .acc_cycles(acc_cycles),
      .oe_cycles (oe_cycles),
      .df_cycles (df_cycles)
   );

   eprom_rd_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .ID_LINE(ID_LINE)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_id    (req_id),
      .req_addr  (req_addr),
      .acc_cycles(acc_cycles),
      .oe_cycles (oe_cycles),
      .df_cycles (df_cycles),
      .mem_data  (mem_data),
      .busy      (busy),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .mem_addr  (mem_addr),
      .mem_ce_n  (mem_ce_n),
      .mem_oe_n  (mem_oe_n),
      .mem_hv_req(mem_hv_req)
   );

endmodule

// File: tb/test_eprom_rd_ctrl.sv
module test_eprom_rd_ctrl;

   localparam int CLK_NS = 10;
   localparam logic [7:0] MAKER_CODE = 8'h3C;
   localparam logic [7:0] PART_CODE  = 8'hA7;
   localparam logic [7:0] JUNK       = 8'hEE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_id = 1'b0;
   logic [15:0] req_addr = '0;
   logic [1:0]  grade = '0;
   logic        busy, rsp_valid, mem_ce_n, mem_oe_n, mem_hv_req;
   logic [7:0]  rsp_data, mem_data;
   logic [15:0] mem_addr;

   always #(CLK_NS / 2) clk = ~clk;

   eprom_rd_ctrl #(.CLK_PERIOD_NS(CLK_NS)) i_eprom_rd_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
      .req_addr(req_addr), .grade(grade), .busy(busy), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
      .mem_oe_n(mem_oe_n), .mem_hv_req(mem_hv_req), .mem_data(mem_data)
   );

   int tacc_ns [4] = '{90, 120, 150, 150};
   int toe_ns  [4] = '{40, 50, 50, 50};
   int tdf_ns  [4] = '{35, 25, 45, 45};

   int vectors = 0;
   int fails   = 0;

   function automatic int up(input int ns);
      return (ns + CLK_NS - 1) / CLK_NS;
   endfunction

   function automatic logic [7:0] rom(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   // ---------------- reference model: timestamps of the current access
   int          cyc = 0;
   int          acc = 0;
   bit          have = 0;
   int          m_nacc = 0, m_d = 0, m_ndf = 0, m_grade = 0;
   bit          m_id = 0;
   logic [15:0] m_addr = '0;
   logic [7:0]  m_data = '0;

   function automatic bit m_busy(input int c);
      return have && c >= acc && c < acc + m_nacc + m_ndf;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         cyc  = 0;
         have = 0;
      end else begin
         if (!m_busy(cyc) && req_valid) begin
            have    = 1;
            acc     = cyc + 1;
            m_grade = int'(grade);
            m_nacc  = up(tacc_ns[m_grade]) + 1;
            m_d     = (tacc_ns[m_grade] - toe_ns[m_grade]) / CLK_NS;
            m_ndf   = up(tdf_ns[m_grade]);
            m_id    = req_id;
            m_addr  = req_id ? (16'h0200 | {15'b0, req_addr[0]}) : req_addr;
            m_data  = req_id ? (req_addr[0] ? PART_CODE : MAKER_CODE) : rom(req_addr);
         end
         cyc = cyc + 1;
      end
   end

   // ---------------- EPROM model: junk until the delays have really elapsed
   int ce_cnt = 0, oe_cnt = 0;
   always @(negedge clk) begin
      ce_cnt = mem_ce_n ? 0 : ce_cnt + 1;
      oe_cnt = mem_oe_n ? 0 : oe_cnt + 1;
   end

   always_comb begin
      logic [7:0] content;
      if (mem_hv_req)
         content = (mem_addr[15:1] == 15'h0100) ? (mem_addr[0] ? PART_CODE : MAKER_CODE) : JUNK;
      else
         content = rom(mem_addr);
      if (!mem_ce_n && !mem_oe_n && ce_cnt >= up(tacc_ns[m_grade]) && oe_cnt >= up(toe_ns[m_grade]))
         mem_data = content;
      else
         mem_data = JUNK;
   end

   // ---------------- compare on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         bit e_ce, e_oe, e_rv;
         e_ce = have && cyc >= acc && cyc < acc + m_nacc;
         e_oe = have && cyc >= acc + m_d && cyc < acc + m_nacc;
         e_rv = have && cyc == acc + m_nacc;
         chk("R2", "mem_ce_n", int'(mem_ce_n), int'(!e_ce));
         chk("R5", "mem_oe_n", int'(mem_oe_n), int'(!e_oe));
         chk("R6", "busy", int'(busy), int'(m_busy(cyc)));
         chk("R3/R9", "rsp_valid", int'(rsp_valid), int'(e_rv));
         chk("R7", "mem_hv_req", int'(mem_hv_req), int'(e_ce && m_id));
         if (e_ce) chk(m_id ? "R7" : "R8", "mem_addr", int'(mem_addr), int'(m_addr));
         if (e_rv) chk(m_id ? "R7" : "R3", "rsp_data", int'(rsp_data), int'(m_data));
      end
   end

   // ---------------- stimulus
   task automatic wait_idle();
      int guard = 0;
      while (m_busy(cyc) && guard < 200) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic rd(input logic [15:0] a, input logic id, input int g);
      int low = 0, bsy = 0, guard = 0;
      req_addr  = a;
      req_id    = id;
      grade     = g[1:0];
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (busy && guard < 200) begin
         if (!mem_ce_n) low++;
         bsy++;
         @(negedge clk);
         guard++;
      end
      // R4: grade sets the access length; R6: float interval extends busy
      chk("R4", "ce low cycles", low, up(tacc_ns[g]) + 1);
      chk("R6", "busy cycles", bsy, up(tacc_ns[g]) + 1 + up(tdf_ns[g]));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "ce_n in reset", int'(mem_ce_n), 1);
      chk("R1", "oe_n in reset", int'(mem_oe_n), 1);
      chk("R1", "busy in reset", int'(busy), 0);
      chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
      chk("R1", "hv_req in reset", int'(mem_hv_req), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 R4 R5: one read per grade code
      rd(16'h1234, 1'b0, 0);
      rd(16'hFFFF, 1'b0, 1);
      rd(16'h0000, 1'b0, 2);
      rd(16'h8001, 1'b0, 3);

      // R7: identifier reads, code select from bit 0
      rd(16'hFFFE, 1'b1, 0);
      rd(16'h0001, 1'b1, 2);

      // R6: request during an access is ignored; R4: grade change is not taken
      req_addr = 16'h4321; req_id = 1'b0; grade = 2'd2; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      req_addr = 16'h7777; req_id = 1'b1; grade = 2'd0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (14) @(negedge clk);
      req_valid = 1'b1;                 // pulse again inside the float interval
      @(negedge clk);
      req_valid = 1'b0;
      wait_idle();

      // R2 R6: request held high across several accesses
      req_addr = 16'hA55A; req_id = 1'b0; grade = 2'd0; req_valid = 1'b1;
      repeat (40) @(negedge clk);
      req_valid = 1'b0;
      wait_idle();

      rd(16'h00FF, 1'b0, 1);
      repeat (4) @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule